// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Window

This block gives a host access to a window of 39 byte-wide chipset configuration registers through two I/O ports. The low address bit picks the port. A write to the even port chooses a register. A write to the odd port stores a byte into the chosen register and then drops the selection back to an idle value of zero. The selection must be chosen again before each data write. The contents of the selected register are visible on a read bus whenever the selection lies inside the window.

One register of the window drives three peripheral enables: the primary disk channel, the serial port pair, and the parallel port. The block compares each byte written to that register with the byte it replaces. For every enable whose value flips, it raises a change strobe for one cycle so that the peripheral logic outside the block can be brought up or torn down. One other register of the window is write-protected. Writes to it are taken as accesses, but its stored value never changes.

Top module: `cfg_window_top`

## Requirements
- R1: After reset the selection is 0, every register holds 0x00, all three enables and all three change strobes are low, and `cfg_rdata` reads 0xFF.
- R2: A write with `io_addr0`=0 goes to the index port and never changes register contents. A write with `io_addr0`=1 goes to the data port and never loads a new selection.
- R3: An index write is taken only when the byte is between 0x50 and 0x76 inclusive. Any other byte leaves the selection as it was.
- R4: A data write made while the selection is outside 0x50..0x76 changes no register and leaves the selection unchanged.
- R5: Register storage is addressed by selection minus 0x50. `cfg_rdata` shows the selected register when the selection is in the window, and 0xFF otherwise.
- R6: A data write while the selection is 0x52 leaves that register's stored value unchanged.
- R7: Every data write made while the selection is in the window, including a write to 0x52, returns the selection to 0 on the next cycle.
- R8: Register 0x73 bit 6 drives `ide_en`, bit 5 drives `uart_en` (both serial ports), and bit 4 drives `lpt_en`.
- R9: In the cycle after a data write to 0x73, each of `ide_chg`, `uart_chg` and `lpt_chg` is high exactly when the XOR of the new byte and the old byte has that enable's bit set. In every other cycle all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Port write strobe, one byte per cycle |
| io_addr0 | input | 1 | Port select: 0 index port, 1 data port |
| io_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Selected register, or 0xFF when the selection is outside the window |
| ide_en | output | 1 | Primary disk channel enable |
| uart_en | output | 1 | Serial port pair enable |
| lpt_en | output | 1 | Parallel port enable |
| ide_chg | output | 1 | One-cycle strobe: `ide_en` flipped |
| uart_chg | output | 1 | One-cycle strobe: `uart_en` flipped |
| lpt_chg | output | 1 | One-cycle strobe: `lpt_en` flipped |

## Verification
The assertions check several rules on every cycle:
- the selection is either zero or inside the window;
- rejected index bytes and ignored data writes leave the selection alone;
- a data write always clears the selection;
- the protected register never moves;
- each change strobe matches a real flip of its enable, in both directions.

Only the bench scenarios can show the following:
- the byte returned for each selection is the right one, with storage laid out at selection minus 0x50;
- bytes written outside the window never land anywhere;
- the strobes stay low when the same value is written again, or when a different register is written.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  // True when a byte falls inside the register window [lo, hi].
  function automatic logic in_window(input logic [7:0] v,
                                     input logic [7:0] lo,
                                     input logic [7:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Storage slot of a window byte.
  function automatic logic [7:0] slot_of(input logic [7:0] v,
                                         input logic [7:0] lo);
    return v - lo;
  endfunction

  // Bits of an enable field that differ between old and new bytes.
  function automatic logic [7:0] flipped(input logic [7:0] old_b,
                                         input logic [7:0] new_b);
    return old_b ^ new_b;
  endfunction

endpackage

// File: rtl/cfg_index_ctl.sv
module cfg_index_ctl
  import cfg_window_pkg::*;
#(
  parameter logic [7:0] WIN_LO = 8'h50,
  parameter logic [7:0] WIN_HI = 8'h76
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_addr0,
  input  logic [7:0] io_wdata,
  output logic [7:0] sel_q,
  output logic       sel_valid,
  output logic       data_commit
);

  logic idx_write;
  logic idx_accept;

  assign idx_write   = io_wr && !io_addr0;
  assign idx_accept  = idx_write && in_window(io_wdata, WIN_LO, WIN_HI);
  assign sel_valid   = in_window(sel_q, WIN_LO, WIN_HI);
  assign data_commit = io_wr && io_addr0 && sel_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)           sel_q <= '0;
    else if (idx_accept)  sel_q <= io_wdata;
    else if (data_commit) sel_q <= '0;
  end

  assert_sel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 8'h00) || in_window(sel_q, WIN_LO, WIN_HI));

  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_write && !in_window(io_wdata, WIN_LO, WIN_HI)) |=> $stable(sel_q));

  assert_ignored_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr0 && !sel_valid) |=> $stable(sel_q));

  assert_sel_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_commit |=> (sel_q == 8'h00));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned NREG      = 39,
  parameter int unsigned SW        = $clog2(NREG),
  parameter int unsigned LOCK_SLOT = 2,
  parameter int unsigned CTL_SLOT  = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] slot,
  input  logic [7:0]    wdata,
  output logic [7:0]    rd_word,
  output logic [7:0]    ctl_word
);

  logic [7:0] regs [NREG];
  logic       lock_hit;

  assign lock_hit = (slot == SW'(LOCK_SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && !lock_hit) begin
      regs[slot] <= wdata;
    end
  end

  assign rd_word  = regs[slot];
  assign ctl_word = regs[CTL_SLOT];

  assert_locked_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock_hit) |=> $stable(regs[LOCK_SLOT]));

endmodule

// File: rtl/cfg_periph_decode.sv
module cfg_periph_decode
  import cfg_window_pkg::*;
#(
  parameter int unsigned IDE_BIT  = 6,
  parameter int unsigned UART_BIT = 5,
  parameter int unsigned LPT_BIT  = 4,
  parameter int unsigned NEN      = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic [7:0]     ctl_old,
  input  logic [7:0]     ctl_new,
  output logic [NEN-1:0] en,
  output logic [NEN-1:0] chg
);

  localparam int unsigned POS [NEN] = '{IDE_BIT, UART_BIT, LPT_BIT};

  logic [7:0] diff;
  assign diff = flipped(ctl_old, ctl_new);

  for (genvar g = 0; g < NEN; g++) begin : g_en
    assign en[g] = ctl_old[POS[g]];

    always_ff @(posedge clk) begin
      if (!rst_n) chg[g] <= 1'b0;
      else        chg[g] <= ctl_we && diff[POS[g]];
    end

    assert_chg_real_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chg[g] |-> (en[g] != $past(en[g])));

    assert_flip_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] != $past(en[g])) |-> chg[g]);
  end

endmodule

// File: rtl/cfg_window_top.sv
module cfg_window_top
  import cfg_window_pkg::*;
#(
  parameter logic [7:0]  WIN_LO   = 8'h50,
  parameter logic [7:0]  WIN_HI   = 8'h76,
  parameter logic [7:0]  LOCK_IDX = 8'h52,
  parameter logic [7:0]  CTL_IDX  = 8'h73,
  parameter int unsigned IDE_BIT  = 6,
  parameter int unsigned UART_BIT = 5,
  parameter int unsigned LPT_BIT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_addr0,
  input  logic [7:0] io_wdata,
  output logic [7:0] cfg_rdata,
  output logic       ide_en,
  output logic       uart_en,
  output logic       lpt_en,
  output logic       ide_chg,
  output logic       uart_chg,
  output logic       lpt_chg
);

  localparam int unsigned NREG      = int'(WIN_HI) - int'(WIN_LO) + 1;
  localparam int unsigned SW        = $clog2(NREG);
  localparam int unsigned LOCK_SLOT = int'(LOCK_IDX) - int'(WIN_LO);
  localparam int unsigned CTL_SLOT  = int'(CTL_IDX) - int'(WIN_LO);
  localparam logic        CTL_LOCKED = (CTL_IDX == LOCK_IDX);

  logic [7:0]    sel_q;
  logic          sel_valid;
  logic          data_commit;
  logic [SW-1:0] slot;
  logic [7:0]    rd_word;
  logic [7:0]    ctl_word;
  logic          ctl_we;
  logic [2:0]    en_vec;
  logic [2:0]    chg_vec;

  cfg_index_ctl #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_index (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr0(io_addr0),
    .io_wdata(io_wdata), .sel_q(sel_q), .sel_valid(sel_valid),
    .data_commit(data_commit)
  );

  assign slot = sel_valid ? SW'(slot_of(sel_q, WIN_LO)) : '0;

  cfg_reg_bank #(.NREG(NREG), .SW(SW), .LOCK_SLOT(LOCK_SLOT), .CTL_SLOT(CTL_SLOT)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(data_commit), .slot(slot),
    .wdata(io_wdata), .rd_word(rd_word), .ctl_word(ctl_word)
  );

  assign ctl_we = data_commit && (sel_q == CTL_IDX) && !CTL_LOCKED;

  cfg_periph_decode #(.IDE_BIT(IDE_BIT), .UART_BIT(UART_BIT), .LPT_BIT(LPT_BIT), .NEN(3)) u_decode (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_old(ctl_word),
    .ctl_new(io_wdata), .en(en_vec), .chg(chg_vec)
  );

  assign cfg_rdata = sel_valid ? rd_word : 8'hFF;
  assign ide_en    = en_vec[0];
  assign uart_en   = en_vec[1];
  assign lpt_en    = en_vec[2];
  assign ide_chg   = chg_vec[0];
  assign uart_chg  = chg_vec[1];
  assign lpt_chg   = chg_vec[2];

  assert_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_chg || uart_chg || lpt_chg) |-> $past(ctl_we));

endmodule

// File: tb/cfg_window_top_tb_top.sv
`timescale 1ns/1ps
module cfg_window_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0;
  logic       io_addr0 = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       ide_en, uart_en, lpt_en, ide_chg, uart_chg, lpt_chg;

  int total = 0;
  int failed = 0;

  logic [7:0] m_sel;
  logic [7:0] m_regs [39];
  logic [2:0] m_chg;  // {ide, uart, lpt}

  always #2.5 clk = ~clk;

  cfg_window_top dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr0(io_addr0),
    .io_wdata(io_wdata), .cfg_rdata(cfg_rdata),
    .ide_en(ide_en), .uart_en(uart_en), .lpt_en(lpt_en),
    .ide_chg(ide_chg), .uart_chg(uart_chg), .lpt_chg(lpt_chg)
  );

  function automatic bit win(input logic [7:0] v);
    return v inside {[8'h50:8'h76]};
  endfunction

  function automatic logic [7:0] exp_rdata();
    return win(m_sel) ? m_regs[m_sel - 8'h50] : 8'hFF;
  endfunction

  function automatic logic [2:0] exp_en();
    logic [7:0] c;
    c = m_regs[8'h73 - 8'h50];
    return {c[6], c[5], c[4]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model update for one port write, applied at the write edge.
  task automatic model_write(input logic a0, input logic [7:0] d);
    logic [7:0] old;
    m_chg = 3'b000;
    if (!a0) begin
      if (win(d)) m_sel = d;
    end else if (win(m_sel)) begin
      old = m_regs[m_sel - 8'h50];
      if (m_sel == 8'h73) m_chg = {old[6] ^ d[6], old[5] ^ d[5], old[4] ^ d[4]};
      if (m_sel != 8'h52) m_regs[m_sel - 8'h50] = d;
      m_sel = 8'h00;
    end
  endtask

  task automatic port_write(input logic a0, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr0 = a0; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    model_write(a0, d);
  endtask

  task automatic check_all(input string req);
    check(req, {8'h00, cfg_rdata}, {8'h00, exp_rdata()});
    check(req, {13'h0, ide_en, uart_en, lpt_en}, {13'h0, exp_en()});
    check(req, {13'h0, ide_chg, uart_chg, lpt_chg}, {13'h0, m_chg});
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    m_chg = 3'b000;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    m_sel = 8'h00; m_chg = 3'b000;
    for (int i = 0; i < 39; i++) m_regs[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    check("R1 rdata reset", {8'h00, cfg_rdata}, 16'h00FF);

    // R4: data write with idle selection ignored
    port_write(1'b1, 8'hC3); check_all("R4 idle data write");
    port_write(1'b0, 8'h50); check_all("R4 reg50 untouched");
    port_write(1'b1, 8'h11);

    // R3: out-of-window index bytes rejected
    port_write(1'b0, 8'h4F); check_all("R3 index 0x4F rejected");
    port_write(1'b0, 8'h77); check_all("R3 index 0x77 rejected");
    port_write(1'b0, 8'h76); check_all("R3 index 0x76 accepted");
    check("R3 selection 0x76 readable", {8'h00, cfg_rdata}, 16'h0000);
    port_write(1'b0, 8'hFF); check_all("R3 index 0xFF keeps 0x76");

    // R5/R7: store, selection clears, reselect reads back
    port_write(1'b1, 8'h5A); check_all("R7 selection cleared");
    check("R7 rdata after clear", {8'h00, cfg_rdata}, 16'h00FF);
    port_write(1'b0, 8'h76); check_all("R5 readback 0x76");
    check("R5 readback value", {8'h00, cfg_rdata}, 16'h005A);
    port_write(1'b0, 8'h50); check_all("R5 slot 0 holds 0x11");

    // R6: protected register
    port_write(1'b0, 8'h52); port_write(1'b1, 8'hAA); check_all("R6 write to 0x52 clears sel");
    port_write(1'b0, 8'h52); check_all("R6 0x52 unchanged");
    check("R6 0x52 value", {8'h00, cfg_rdata}, 16'h0000);

    // R8/R9: enables and change strobes
    port_write(1'b0, 8'h73); port_write(1'b1, 8'h70); check_all("R9 all enables flip");
    check("R8 enables on", {13'h0, ide_en, uart_en, lpt_en}, 16'h0007);
    idle_check("R9 strobe one cycle");
    port_write(1'b0, 8'h73); port_write(1'b1, 8'h70); check_all("R9 same value no strobe");
    port_write(1'b0, 8'h73); port_write(1'b1, 8'h50); check_all("R9 serial only flips");
    check("R9 uart strobe", {13'h0, ide_chg, uart_chg, lpt_chg}, 16'h0002);
    port_write(1'b0, 8'h74); port_write(1'b1, 8'hFF); check_all("R9 other reg no strobe");
    port_write(1'b0, 8'h73); port_write(1'b1, 8'h8F); check_all("R8 non-enable bits");

    // R2: random mix of index and data writes
    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      logic a0;
      logic [7:0] d;
      a0 = 1'($urandom % 2);
      if ($urandom % 3 != 0) d = 8'h50 + 8'($urandom % 39);
      else                   d = 8'($urandom);
      if ($urandom % 4 == 0) d = 8'h73;
      port_write(a0, d);
      check_all("R2 random port access");
      if ($urandom % 5 == 0) idle_check("R9 random idle");
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule